// File: doc/BRIEF.md
# Lane-Partitioned Saturating Adder/Subtractor

This block is a purely combinational 64-bit adder/subtractor. Its carry chain can be cut into independent lanes at run time. One 64-bit operand pair is treated as eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane is added or subtracted on its own, and no carry or borrow crosses a lane boundary. Subtraction adds the bit-inverted second operand, with a carry-in of one forced into the lowest bit of every lane.

Each lane can be read as signed or unsigned. When a lane overflows, the block raises a flag for that lane. In clamping mode the lane is then replaced by the representable extreme that lies in the direction of the overflow. In wrapping mode the lane keeps the modulo result. The flags come out as one bit per byte, so software can read them in the same way for every lane size. The block has no clock and no state: a datapath stage places it between its own registers.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_sz_i` selects the lane width: 0 selects 8 bits, 1 selects 16 bits, 2 and 3 both select 32 bits. No carry or borrow passes from one lane into the next.
- R2: With `sub_i`=0 and `sat_i`=0, every lane of `sum_o` is (a + b) mod 2^w, where w is the lane width.
- R3: With `sub_i`=1 and `sat_i`=0, every lane of `sum_o` is (a + ~b + 1) mod 2^w, which equals a - b mod 2^w.
- R4: With `signed_i`=1, a lane overflows in these cases. On add, it overflows only when both operands have the same sign and the result sign differs from it. On subtract, it overflows only when the operand signs differ and the result sign differs from the sign of a.
- R5: With `signed_i`=0, a lane overflows on add when it carries out of its top bit, and on subtract when a < b (borrow).
- R6: With `sat_i`=1 and `signed_i`=1, an overflowing lane becomes 2^(w-1)-1 when a is non-negative and -2^(w-1) when a is negative.
- R7: With `sat_i`=1 and `signed_i`=0, an overflowing lane becomes all ones on add and zero on subtract.
- R8: Bit k of `ovf_o` belongs to byte k, which is bits 8k+7 to 8k. It holds the overflow flag of the lane that contains that byte, so a wider lane repeats its flag in every one of its byte positions.
- R9: The overflow flags are produced in wrapping mode as well. In that mode they leave the wrapped result unchanged.
- R10: `sum_o` and `ovf_o` depend only on the present inputs and hold no state. They settle in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand (minuend on subtract) |
| b_i | input | 64 | Second operand (subtrahend on subtract) |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| lane_sz_i | input | 2 | Lane width code: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| sat_i | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| signed_i | input | 1 | 1 = lanes are two's-complement, 0 = unsigned |
| sum_o | output | 64 | Per-lane result |
| ovf_o | output | 8 | Per-byte copy of the overflow flag of the enclosing lane |

## Verification
The block has no registers, so both `sum_o` and `ovf_o` are due zero cycles after a change on any input. The bench drives each vector 2 ns after a clock edge and samples 1 ns later. This keeps every sample between edges and inside the same cycle as its stimulus. The 8-bit lane width is swept over every operand pair in all eight combinations of add/subtract, wrap/clamp and signed/unsigned. The wider lane widths are covered by boundary values and pseudo-random operands, and each result is compared against a lane-by-lane arithmetic model in the bench.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_B32A = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/simd_lane_map.sv
// Works out, for every byte slice, whether a lane starts there and
// which byte slice is the top (sign) byte of its lane.
// Requires NB >= 4 so that a 32-bit lane fits.
module simd_lane_map
  import simd_sat_pkg::*;
#(
  parameter int unsigned NB = 8,
  localparam int unsigned IDXW = $clog2(NB)
) (
  input  lane_sz_e                  lane_sz_i,
  output logic [NB-1:0]             first_o,
  output logic [NB-1:0][IDXW-1:0]   top_idx_o
);
  logic [IDXW-1:0] span_m1;

  always_comb begin
    unique case (lane_sz_i)
      LANE_B8:  span_m1 = IDXW'(0);
      LANE_B16: span_m1 = IDXW'(1);
      default:  span_m1 = IDXW'(3);
    endcase
  end

  for (genvar i = 0; i < NB; i++) begin : g_map
    assign first_o[i]   = ((IDXW'(i) & span_m1) == '0);
    assign top_idx_o[i] = IDXW'(i) | span_m1;
  end
endmodule

// File: rtl/simd_byte_add.sv
// One byte slice of the adder. It brings out the carry into its top bit
// so that signed overflow can be found where the slice tops a lane.
module simd_byte_add #(
  parameter int unsigned BW = 8
) (
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  input  logic          sub_i,
  input  logic          cin_i,
  output logic [BW-1:0] sum_o,
  output logic          c_msb_o,
  output logic          cout_o
);
  logic [BW-1:0] b_eff;
  logic [BW-1:0] low;
  logic [1:0]    hi;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    low     = {1'b0, a_i[BW-2:0]} + {1'b0, b_eff[BW-2:0]} + {{(BW-1){1'b0}}, cin_i};
    c_msb_o = low[BW-1];
    hi      = {1'b0, a_i[BW-1]} + {1'b0, b_eff[BW-1]} + {1'b0, c_msb_o};
    sum_o   = {hi[0], low[BW-2:0]};
    cout_o  = hi[1];
  end
endmodule

// File: rtl/simd_sat_select.sv
// Picks, for one byte, between the wrapped sum and the clamp value of
// its lane.
module simd_sat_select #(
  parameter int unsigned BW = 8
) (
  input  logic [BW-1:0] wrap_i,
  input  logic          is_top_i,
  input  logic          ovf_i,
  input  logic          sat_i,
  input  logic          signed_i,
  input  logic          sub_i,
  input  logic          neg_i,
  output logic [BW-1:0] out_o
);
  logic [BW-1:0] clamp;

  always_comb begin
    if (signed_i) begin
      if (neg_i) clamp = is_top_i ? {1'b1, {(BW-1){1'b0}}} : '0;
      else       clamp = is_top_i ? {1'b0, {(BW-1){1'b1}}} : '1;
    end else begin
      clamp = sub_i ? '0 : '1;
    end
    out_o = (sat_i && ovf_i) ? clamp : wrap_i;
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_sat_pkg::*;
#(
  parameter int unsigned W = 64,
  localparam int unsigned NB = W / BYTE_W,
  localparam int unsigned IDXW = $clog2(NB)
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          sub_i,
  input  logic [1:0]    lane_sz_i,
  input  logic          sat_i,
  input  logic          signed_i,
  output logic [W-1:0]  sum_o,
  output logic [NB-1:0] ovf_o
);
  logic [NB-1:0]            first;
  logic [NB-1:0][IDXW-1:0]  top_idx;
  logic [NB-1:0]            ovf_raw;
  logic [NB-1:0]            a_msb;
  logic [W-1:0]             wrap_sum;

  simd_lane_map #(.NB(NB)) u_map (
    .lane_sz_i (lane_sz_e'(lane_sz_i)),
    .first_o   (first),
    .top_idx_o (top_idx)
  );

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic cin;
    logic c_msb;
    logic cout;

    if (i == 0) begin : g_lsb
      assign cin = sub_i;
    end else begin : g_mid
      // the chain is cut wherever a new lane begins
      assign cin = first[i] ? sub_i : g_byte[i-1].cout;
    end

    simd_byte_add #(.BW(BYTE_W)) u_add (
      .a_i     (a_i[i*BYTE_W +: BYTE_W]),
      .b_i     (b_i[i*BYTE_W +: BYTE_W]),
      .sub_i   (sub_i),
      .cin_i   (cin),
      .sum_o   (wrap_sum[i*BYTE_W +: BYTE_W]),
      .c_msb_o (c_msb),
      .cout_o  (cout)
    );

    assign a_msb[i]   = a_i[i*BYTE_W + BYTE_W - 1];
    // only meaningful in the byte slice that tops a lane
    assign ovf_raw[i] = signed_i ? (c_msb ^ cout) : (sub_i ? ~cout : cout);
    assign ovf_o[i]   = ovf_raw[top_idx[i]];

    simd_sat_select #(.BW(BYTE_W)) u_sel (
      .wrap_i   (wrap_sum[i*BYTE_W +: BYTE_W]),
      .is_top_i (top_idx[i] == IDXW'(i)),
      .ovf_i    (ovf_o[i]),
      .sat_i    (sat_i),
      .signed_i (signed_i),
      .sub_i    (sub_i),
      .neg_i    (a_msb[top_idx[i]]),
      .out_o    (sum_o[i*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int unsigned W = 64,
  localparam int unsigned NB = W / 8
) (
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic          sub_i,
  input logic [1:0]    lane_sz_i,
  input logic          sat_i,
  input logic          signed_i,
  input logic [W-1:0]  sum_o,
  input logic [NB-1:0] ovf_o
);
  int unsigned span;

  always_comb begin
    span = (lane_sz_i == 2'd0) ? 1 : (lane_sz_i == 2'd1) ? 2 : 4;
    if (!$isunknown({a_i, b_i, sub_i, lane_sz_i, sat_i, signed_i})) begin
      for (int i = 0; i < NB; i++) begin
        // R8
        flag_repl_chk: assert (ovf_o[i] == ovf_o[(i / span) * span + span - 1]);
        if ((i % span) == span - 1) begin
          // R4
          mixed_sign_chk: assert (!(signed_i && !sub_i &&
                                    (a_i[8*i+7] != b_i[8*i+7]) && ovf_o[i]));
          // R6
          ssat_top_chk: assert (!(signed_i && sat_i && ovf_o[i]) ||
                                (sum_o[8*i +: 8] == (a_i[8*i+7] ? 8'h80 : 8'h7F)));
        end
        // R7
        usat_hi_chk: assert (!(!signed_i && sat_i && !sub_i && ovf_o[i]) ||
                             (sum_o[8*i +: 8] == 8'hFF));
        // R7
        usat_lo_chk: assert (!(!signed_i && sat_i && sub_i && ovf_o[i]) ||
                             (sum_o[8*i +: 8] == 8'h00));
      end
    end
  end
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.W(W)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .sub_i     (sub_i),
  .lane_sz_i (lane_sz_i),
  .sat_i     (sat_i),
  .signed_i  (signed_i),
  .sum_o     (sum_o),
  .ovf_o     (ovf_o)
);

// File: tb/simd_sat_adder_bench.sv
module simd_sat_adder_bench;
  logic        clk = 1'b0;
  logic [63:0] a, b;
  logic        sub, sat, sgn;
  logic [1:0]  lsz;
  logic [63:0] sum;
  logic [7:0]  ovf;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_sat_adder u_simd_sat_adder (
    .a_i(a), .b_i(b), .sub_i(sub), .lane_sz_i(lsz),
    .sat_i(sat), .signed_i(sgn), .sum_o(sum), .ovf_o(ovf)
  );

  function automatic int lane_w(input logic [1:0] code);
    return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
  endfunction

  // arithmetic model of one lane of width w
  function automatic void model_lane(input int w, input longint unsigned x, y,
                                     input bit s_sub, s_sat, s_sgn,
                                     output longint unsigned r, output bit ov);
    longint unsigned m = (64'd1 << w) - 64'd1;
    longint sx, sy, full, mx, mn;
    if (!s_sgn) begin
      if (!s_sub) begin
        ov = (x + y) > m;
        r  = (ov && s_sat) ? m : ((x + y) & m);
      end else begin
        ov = x < y;
        r  = (ov && s_sat) ? 64'd0 : ((x - y) & m);
      end
    end else begin
      sx = x[w-1] ? longint'(x) - longint'(m) - 1 : longint'(x);
      sy = y[w-1] ? longint'(y) - longint'(m) - 1 : longint'(y);
      full = s_sub ? sx - sy : sx + sy;
      mx = (longint'(1) <<< (w - 1)) - 1;
      mn = -mx - 1;
      ov = (full > mx) || (full < mn);
      if (ov && s_sat) r = longint'(full > mx ? mx : mn) & m;
      else             r = longint'(full) & m;
    end
  endfunction

  task automatic apply_check(input string tag);
    logic [63:0] exp_sum;
    logic [7:0]  exp_ovf;
    longint unsigned r;
    bit ov;
    int w;
    int nb;
    w  = lane_w(lsz);
    nb = w / 8;
    exp_sum = '0;
    exp_ovf = '0;
    for (int l = 0; l < 64 / w; l++) begin
      model_lane(w, (a >> (l * w)) & ((64'd1 << w) - 1), (b >> (l * w)) & ((64'd1 << w) - 1),
                 sub, sat, sgn, r, ov);
      exp_sum |= r << (l * w);
      for (int k = 0; k < nb; k++) exp_ovf[l * nb + k] = ov;
    end
    // R10: no register in the path, so results are due 1 ns after the drive
    #1;
    n_chk++;
    if (sum !== exp_sum) begin
      n_fail++;
      $display("FAIL %s sum sz=%0d sub=%0b sat=%0b sgn=%0b a=%h b=%h got %h exp %h",
               tag, lsz, sub, sat, sgn, a, b, sum, exp_sum);
    end
    n_chk++;
    if (ovf !== exp_ovf) begin
      n_fail++;
      $display("FAIL %s/R8 flags sz=%0d sub=%0b sat=%0b sgn=%0b a=%h b=%h got %h exp %h",
               sgn ? "R4" : "R5", lsz, sub, sat, sgn, a, b, ovf, exp_ovf);
    end
    #4;
  endtask

  function automatic string mode_tag(input bit s_sub, s_sat, s_sgn);
    if (s_sat) return s_sgn ? "R6" : "R7";
    return s_sub ? "R3" : "R2";
  endfunction

  function automatic logic [63:0] rep(input int w, input longint unsigned v);
    logic [63:0] o = '0;
    for (int l = 0; l < 64 / w; l++) o |= (v & ((64'd1 << w) - 1)) << (l * w);
    return o;
  endfunction

  initial begin
    longint unsigned edges[5];
    int w;
    a = '0; b = '0; sub = 0; sat = 0; sgn = 0; lsz = 2'd0;
    #2;
    // quiet inputs give a zero result and no flags (R2)
    apply_check("R2");

    // R1: carry must stop at every lane boundary
    lsz = 2'd0; a = 64'h00FF00FF00FF00FF; b = 64'h0001000100010001; apply_check("R1");
    lsz = 2'd1; a = 64'h0000FFFF0000FFFF; b = 64'h0000000100000001; apply_check("R1");
    lsz = 2'd2; a = 64'h00000000FFFFFFFF; b = 64'h0000000000000001; apply_check("R1");
    sub = 1;   a = 64'h0000000100000000; b = 64'h0000000000000001; apply_check("R1");
    lsz = 2'd3; apply_check("R1");
    // R9: wrapped result stays modulo while the flag is raised
    sub = 0; sgn = 1; lsz = 2'd0; a = {8{8'h7F}}; b = {8{8'h01}}; apply_check("R9");

    // exhaustive 8-bit lane sweep over every operand pair and mode
    lsz = 2'd0;
    for (int md = 0; md < 8; md++) begin
      {sub, sat, sgn} = md[2:0];
      for (int x = 0; x < 256; x++)
        for (int bb = 0; bb < 32; bb++) begin
          a = {8{x[7:0]}};
          for (int k = 0; k < 8; k++) b[8*k +: 8] = 8'(bb * 8 + k);
          apply_check(mode_tag(sub, sat, sgn));
        end
    end

    // boundaries and random operands for every lane width (R1 covers code 3)
    for (int sz = 0; sz < 4; sz++) begin
      lsz = sz[1:0];
      w = lane_w(lsz);
      edges[0] = 0; edges[1] = 1; edges[2] = (64'd1 << (w - 1)) - 1;
      edges[3] = 64'd1 << (w - 1); edges[4] = (64'd1 << w) - 1;
      for (int md = 0; md < 8; md++) begin
        {sub, sat, sgn} = md[2:0];
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++) begin
            a = rep(w, edges[i]); b = rep(w, edges[j]);
            apply_check(mode_tag(sub, sat, sgn));
          end
        for (int n = 0; n < 300; n++) begin
          a = {$urandom, $urandom}; b = {$urandom, $urandom};
          apply_check(mode_tag(sub, sat, sgn));
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule